// File: doc/BRIEF.md
# Pin-Change Interrupt Detector

This block watches a set of up to 32 input lines and notes every change of logic level on any of them, whether the level went up or down. Each line owns one bit in a status register. A change sets that bit, and the bit stays set until software reads the status register. The read returns the accumulated bits and then clears them all. A per-line mask register decides which recorded changes may raise the single combined interrupt output. Masked lines still record their changes.

The levels arrive already conditioned by an input filter that sits outside this block. The register decoder also sits outside. It turns bus accesses into one write strobe for mask-enable, one for mask-disable, a shared write data word and a status read strobe. The decoder places mask-enable at offset 0x40, mask-disable at 0x44, the mask read at 0x48 and the status read at 0x4C. Detection works the same whatever owns the pad and whatever its direction, so the block takes no direction or ownership inputs.

Top module: `pin_change_irq`

## Requirements
- R1: A rising level on a line, sampled at one clock edge against the level sampled at the edge before, sets that line's bit of `stat_o`, visible from that edge onward.
- R2: A falling level on a line sets that line's bit of `stat_o` with the same timing as R1.
- R3: A status bit whose line holds its level stays unchanged when no read occurs. A set bit stays set until a read.
- R4: While `stat_rd_i` is high, `stat_o` still shows the accumulated bits. After that clock edge, every bit whose line did not change in that cycle is 0.
- R5: A line change sampled at the same edge as a status read leaves that line's bit set after the edge, so the change is not lost to the clear.
- R6: At a clock edge, `irq_en_we_i` sets each mask bit where `wr_data_i` is 1. `irq_dis_we_i` clears each mask bit where `wr_data_i` is 1. Bits where `wr_data_i` is 0 keep their value. When both strobes are high, disable wins for the bits that are 1 in the data.
- R7: A line whose mask bit is 0 still sets its status bit on a change and can still be read and cleared.
- R8: `irq_o` is 1 exactly when some line has both its status bit and its mask bit at 1. It follows the registered status and mask with no added cycle.
- R9: While `rst` is high at a clock edge, status and mask become 0. A line that holds the level it had during reset records nothing after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl_i | input | LINES | Conditioned level of each watched line |
| irq_en_we_i | input | 1 | Mask-enable write strobe |
| irq_dis_we_i | input | 1 | Mask-disable write strobe |
| wr_data_i | input | LINES | Write data for the mask strobes, one bit per line |
| stat_rd_i | input | 1 | Status read strobe; clears the status after the edge |
| stat_o | output | LINES | Status register read value |
| mask_o | output | LINES | Mask register read value |
| irq_o | output | 1 | Combined interrupt |

## Verification
A status read and a new level change on the same line can meet at one clock edge. So can a mask-enable and a mask-disable aimed at the same bit. The bench provokes both collisions on purpose, using directed cycles and a long random stretch in which reads, toggles and both strobes land together often. A behavioural model decides what the result must be: the fresh change survives the clear, and disable beats enable. Status, mask and interrupt are compared against the model on every cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int PCD_MAX_LINES = 32;

    localparam logic [7:0] PCD_OFS_MASK_SET = 8'h40;
    localparam logic [7:0] PCD_OFS_MASK_CLR = 8'h44;
    localparam logic [7:0] PCD_OFS_MASK_RD  = 8'h48;
    localparam logic [7:0] PCD_OFS_STAT_RD  = 8'h4C;

    typedef enum logic [1:0] {
        MASK_KEEP = 2'b00,
        MASK_SET  = 2'b01,
        MASK_CLR  = 2'b10,
        MASK_BOTH = 2'b11
    } mask_op_e;

    typedef struct packed {
        logic hit;
        logic rd;
        logic cur;
    } stat_bit_t;

    function automatic mask_op_e mask_op_decode(input logic set_we, input logic clr_we);
        return mask_op_e'({clr_we, set_we});
    endfunction

    function automatic logic mask_bit_next(input logic cur, input logic d, input mask_op_e op);
        logic nxt;
        unique case (op)
            MASK_SET:  nxt = cur | d;
            MASK_CLR,
            MASK_BOTH: nxt = cur & ~d;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic stat_bit_next(input stat_bit_t s);
        return s.hit | (s.cur & ~s.rd);
    endfunction

endpackage

// File: rtl/pcd_edge_detect.sv
module pcd_edge_detect #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lvl_i,
    output logic [LINES-1:0] chg_o
);
    logic [LINES-1:0] last_q;

    always_ff @(posedge clk) begin
        last_q <= lvl_i;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign chg_o[g] = !rst && (lvl_i[g] != last_q[g]);
    end
endmodule

// File: rtl/pcd_status_reg.sv
module pcd_status_reg
    import pcd_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] chg_i,
    input  logic             rd_i,
    output logic [LINES-1:0] stat_o
);
    logic [LINES-1:0] stat_q;
    logic [LINES-1:0] stat_d;

    for (genvar g = 0; g < LINES; g++) begin : g_bit
        stat_bit_t sb;
        always_comb begin
            sb.hit    = chg_i[g];
            sb.rd     = rd_i;
            sb.cur    = stat_q[g];
            stat_d[g] = stat_bit_next(sb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/pcd_mask_reg.sv
module pcd_mask_reg
    import pcd_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we_i,
    input  logic             clr_we_i,
    input  logic [LINES-1:0] data_i,
    output logic [LINES-1:0] mask_o
);
    mask_op_e         op;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] mask_d;

    assign op = mask_op_decode(set_we_i, clr_we_i);

    for (genvar g = 0; g < LINES; g++) begin : g_bit
        assign mask_d[g] = mask_bit_next(mask_q[g], data_i[g], op);
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/pcd_irq_merge.sv
module pcd_irq_merge #(
    parameter int LINES = 32
) (
    input  logic [LINES-1:0] stat_i,
    input  logic [LINES-1:0] mask_i,
    output logic             irq_o
);
    logic [LINES-1:0] armed;

    for (genvar g = 0; g < LINES; g++) begin : g_and
        assign armed[g] = stat_i[g] & mask_i[g];
    end

    assign irq_o = |armed;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin_lvl_i,
    input  logic             irq_en_we_i,
    input  logic             irq_dis_we_i,
    input  logic [LINES-1:0] wr_data_i,
    input  logic             stat_rd_i,
    output logic [LINES-1:0] stat_o,
    output logic [LINES-1:0] mask_o,
    output logic             irq_o
);
    initial begin
        if (LINES < 1 || LINES > PCD_MAX_LINES)
            $error("pin_change_irq: LINES out of range");
    end

    logic [LINES-1:0] chg;

    pcd_edge_detect #(.LINES(LINES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (pin_lvl_i),
        .chg_o (chg)
    );

    pcd_status_reg #(.LINES(LINES)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .chg_i  (chg),
        .rd_i   (stat_rd_i),
        .stat_o (stat_o)
    );

    pcd_mask_reg #(.LINES(LINES)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .set_we_i (irq_en_we_i),
        .clr_we_i (irq_dis_we_i),
        .data_i   (wr_data_i),
        .mask_o   (mask_o)
    );

    pcd_irq_merge #(.LINES(LINES)) u_irq (
        .stat_i (stat_o),
        .mask_i (mask_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
    parameter int LINES = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [LINES-1:0] pin_lvl_i,
    input logic             irq_en_we_i,
    input logic             irq_dis_we_i,
    input logic [LINES-1:0] wr_data_i,
    input logic             stat_rd_i,
    input logic [LINES-1:0] stat_o,
    input logic [LINES-1:0] mask_o,
    input logic             irq_o
);
    logic [LINES-1:0] seen;
    always_ff @(posedge clk) seen <= pin_lvl_i;

    // R1 and R2: any toggled line is set after the edge
    p_toggle_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (pin_lvl_i != seen) |=> ((stat_o & $past(pin_lvl_i ^ seen)) == $past(pin_lvl_i ^ seen)));

    // R3: without a read, set bits stay set
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R3: quiet lines never rise in status
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_lvl_i == seen) |=> ((stat_o & ~$past(stat_o)) == '0));

    // R4: read with no new change empties status
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && pin_lvl_i == seen) |=> (stat_o == '0));

    // R6: disable clears the addressed bits, winning over enable
    p_dis_wins_r6: assert property (@(posedge clk) disable iff (rst)
        irq_dis_we_i |=> ((mask_o & $past(wr_data_i)) == '0));

    // R6: enable alone sets the addressed bits
    p_en_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_en_we_i && !irq_dis_we_i) |=> ((mask_o & $past(wr_data_i)) == $past(wr_data_i)));

    // R6: with no strobe the mask holds
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_we_i && !irq_dis_we_i) |=> $stable(mask_o));

    // R8: interrupt only with an armed line
    p_irq_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((stat_o & mask_o) != '0));

    // R8: an armed line raises the interrupt
    p_irq_raised_r8: assert property (@(posedge clk) disable iff (rst)
        ((stat_o & mask_o) != '0) |-> irq_o);

    // R9: reset empties both registers
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (stat_o == '0 && mask_o == '0 && !irq_o));
endmodule

bind pin_change_irq pin_change_irq_chk #(.LINES(LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pin_lvl_i    (pin_lvl_i),
    .irq_en_we_i  (irq_en_we_i),
    .irq_dis_we_i (irq_dis_we_i),
    .wr_data_i    (wr_data_i),
    .stat_rd_i    (stat_rd_i),
    .stat_o       (stat_o),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pin = '0;
    logic         en_we = 1'b0;
    logic         dis_we = 1'b0;
    logic [W-1:0] wd = '0;
    logic         rd = 1'b0;
    logic [W-1:0] stat_o;
    logic [W-1:0] mask_o;
    logic         irq_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    pin_change_irq #(.LINES(W)) u_dut (
        .clk(clk), .rst(rst), .pin_lvl_i(pin), .irq_en_we_i(en_we),
        .irq_dis_we_i(dis_we), .wr_data_i(wd), .stat_rd_i(rd),
        .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    // behavioural reference
    bit [W-1:0] m_prev, m_stat, m_mask;
    always @(posedge clk) begin
        if (rst) begin
            m_prev <= pin;
            m_stat <= '0;
            m_mask <= '0;
        end else begin
            bit [W-1:0] ns;
            bit [W-1:0] nm;
            ns = rd ? '0 : m_stat;
            for (int i = 0; i < W; i++) if (pin[i] !== m_prev[i]) ns[i] = 1'b1;
            nm = m_mask;
            for (int i = 0; i < W; i++) begin
                if (wd[i]) begin
                    if (dis_we)     nm[i] = 1'b0;
                    else if (en_we) nm[i] = 1'b1;
                end
            end
            m_stat <= ns;
            m_mask <= nm;
            m_prev <= pin;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit exp_irq;
            exp_irq = 1'b0;
            for (int i = 0; i < W; i++) if (m_stat[i] && m_mask[i]) exp_irq = 1'b1;
            total++;
            if (stat_o !== m_stat) begin
                bad++;
                $display("FAIL %s status act=%h exp=%h", cur_req, stat_o, m_stat);
            end
            total++;
            if (mask_o !== m_mask) begin
                bad++;
                $display("FAIL %s mask act=%h exp=%h", cur_req, mask_o, m_mask);
            end
            total++;
            if (irq_o !== exp_irq) begin
                bad++;
                $display("FAIL %s irq act=%b exp=%b", cur_req, irq_o, exp_irq);
            end
        end
    end

    task automatic cyc(input bit [W-1:0] p, input bit e, input bit d,
                       input bit [W-1:0] w, input bit r);
        pin = p; en_we = e; dis_we = d; wd = w; rd = r;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(pin, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        bit [W-1:0] p;
        // R9: levels held through reset and release
        cur_req = "R9";
        pin = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(3);
        // R1: rising edges on two lines
        cur_req = "R1";
        p = pin | 32'h0000_0030;
        cyc(p, 0, 0, '0, 0);
        idle(2);
        // R2: falling edges
        cur_req = "R2";
        p = pin & ~32'h8000_0001;
        cyc(p, 0, 0, '0, 0);
        idle(2);
        // R3: level returns, bits remain without a read
        cur_req = "R3";
        cyc(pin ^ 32'h0000_0010, 0, 0, '0, 0);
        idle(4);
        // R4: read clears
        cur_req = "R4";
        cyc(pin, 0, 0, '0, 1);
        idle(2);
        // R5: change in the same cycle as a read
        cur_req = "R5";
        cyc(pin ^ 32'h0000_0100, 0, 0, '0, 0);
        cyc(pin ^ 32'h0001_0000, 0, 0, '0, 1);
        idle(2);
        cyc(pin, 0, 0, '0, 1);
        idle(1);
        // R6: mask writes
        cur_req = "R6";
        cyc(pin, 1, 0, 32'hFF00_00FF, 0);
        cyc(pin, 0, 1, 32'h0F00_000F, 0);
        cyc(pin, 1, 1, 32'h00F0_00F0, 0);
        cyc(pin, 1, 0, 32'h0000_0000, 0);
        cyc(pin, 1, 1, 32'h0000_0001, 0);
        idle(2);
        // R7: masked line still records and clears
        cur_req = "R7";
        cyc(pin ^ 32'h0000_0200, 0, 0, '0, 0);
        idle(2);
        cyc(pin, 0, 0, '0, 1);
        idle(1);
        // R8: armed line raises and a read drops the interrupt
        cur_req = "R8";
        cyc(pin ^ 32'h0000_0080, 0, 0, '0, 0);
        idle(2);
        cyc(pin, 0, 1, 32'h0000_0080, 0);
        cyc(pin, 1, 0, 32'h0000_0080, 0);
        cyc(pin, 0, 0, '0, 1);
        idle(2);
        // R5 R6 R8: random collisions
        cur_req = "R5";
        for (int k = 0; k < 3000; k++) begin
            bit [W-1:0] tog;
            tog = ($urandom_range(0, 2) == 0) ? $urandom() & $urandom() : '0;
            cyc(pin ^ tog, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                $urandom(), $urandom_range(0, 4) == 0);
        end
        // R9: reset mid-run with activity
        cur_req = "R9";
        rst = 1'b1;
        cyc(pin ^ 32'h0000_FFFF, 1, 0, 32'hFFFF_FFFF, 0);
        cyc(pin, 0, 0, '0, 0);
        rst = 1'b0;
        idle(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule